// File: doc/BRIEF.md
# Speech Word Sequencer

This block is the control sequencer of a ROM-driven speech controller. A host places a 6-bit word number on the word inputs and raises `start`. Once `start` falls, the sequencer reads a two-byte entry from a word table at the bottom of the speech ROM and builds a 12-bit pointer from it. It then walks two-byte control records from that pointer. The first byte of a record gives the base of the sample data. The second byte carries the stop, voiced and silence flags, the initial length count and the repeat reload value.

After each record the sequencer enters a play state. In that state an external counter chain drives the ROM address and an external decoder supplies the 4-bit sample. Play lasts until the counter chain reports its length carry. The sequencer then fetches the next record, or, when the stop flag is set, passes through a one-cycle delay state back to idle. A high `start` abandons whatever is in progress and returns the machine to word-wait. The ROM is a plain read port with a fixed latency of one cycle and no handshake: the byte for the address presented in one cycle is taken in the next cycle. The block therefore neither applies nor accepts back-pressure.

Top module: `spk_word_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `play_en`, `dbase_load` and `ctrl_load` are 0, `rom_addr` is 0 and `audio_out` is 7.
- R2: A high `start` on a clock edge puts the machine into word-wait on that edge from any state and sets `busy`. While `start` stays high the machine stays in word-wait and `play_en` stays 0.
- R3: On the edge where word-wait sees `start` low, `rom_addr` becomes the word number times 2. One edge later it becomes the word number times 2 plus 1.
- R4: The pointer is {first table byte, upper nibble of the second table byte}, and it appears on `rom_addr` one edge after the second address.
- R5: On the next edge `dbase_load` pulses for one cycle. `data_base` carries the record's first byte shifted left by 1 with bit 0 clear, and `rom_addr` becomes the pointer plus 1.
- R6: On the next edge `ctrl_load` pulses for one cycle and `play_en` rises. The record's second byte is decoded as follows: bit 7 is `stop_flag`, bit 6 is `voiced_flag`, bit 5 is `silence_flag`, `len_init` is {bits 4:0, 2'b00} and `rpt_reload` is bits 1:0. `rom_addr` becomes {`data_base`, 3'b000}.
- R7: In play, with neither `start` nor `len_carry`, each edge copies `play_addr` into `rom_addr`, and `audio_out` equals `dec_sample`.
- R8: A `len_carry` in play with the stop flag clear leaves play on that edge. `rom_addr` becomes the address of the next record (record start plus 2), and the next record is then fetched as in R5 and R6.
- R9: A `len_carry` in play with the stop flag set moves to a delay state for one cycle and then to idle. `busy` stays high through the first idle cycle and falls on the edge after it.
- R10: `audio_out` is 7 in every state other than play.
- R11: `len_carry` has no effect outside play. The fetch address sequence is the same whether it is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin or restart an utterance |
| word_num | input | 6 | Word number to speak |
| rom_data | input | 8 | ROM byte for the address presented one cycle earlier |
| play_addr | input | 12 | ROM address from the external counter chain during play |
| len_carry | input | 1 | Length-count carry from the counter chain |
| dec_sample | input | 4 | Sample from the external decoder |
| rom_addr | output | 12 | ROM address |
| busy | output | 1 | Utterance in progress, active high |
| play_en | output | 1 | Sequencer is in the play state |
| audio_out | output | 4 | Sample output, 7 outside play |
| dbase_load | output | 1 | One-cycle strobe: load `data_base` into the counter chain |
| data_base | output | 9 | Upper data-address counter value |
| ctrl_load | output | 1 | One-cycle strobe: control record fields valid |
| stop_flag | output | 1 | Record is the last of the word |
| voiced_flag | output | 1 | Record is voiced |
| silence_flag | output | 1 | Record is silent |
| len_init | output | 7 | Initial length-counter value |
| rpt_reload | output | 2 | Repeat reload value |

## Verification
Every result is registered. It appears on the edge that follows the cycle in which the state saw its input. The address sequence therefore advances by exactly one step per edge: word table, pointer, data base, control byte, play. The bench moves one rising edge at a time. It samples and drives one time unit after the edge, so each expected value is compared in the cycle the requirements fix for it. This includes the idle cycle in which `busy` is still high and the edge after it, on which `busy` falls.

// File: rtl/spk_seq_pkg.sv
package spk_seq_pkg;
  localparam int WORD_W  = 6;
  localparam int DATA_W  = 8;
  localparam int NIB_W   = DATA_W / 2;
  localparam int ADDR_W  = DATA_W + NIB_W;
  localparam int BASE_W  = DATA_W + 1;
  localparam int SUB_W   = ADDR_W - BASE_W;
  localparam int LEN_W   = 7;
  localparam int FIELD_W = 5;
  localparam int LEN_SH  = LEN_W - FIELD_W;
  localparam int RPT_W   = 2;
  localparam int SAMP_W  = 4;
  localparam logic [SAMP_W-1:0] REST_LEVEL = SAMP_W'(7);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_PTR_HI = 3'd2,
    ST_PTR_LO = 3'd3,
    ST_BASE   = 3'd4,
    ST_CTRL   = 3'd5,
    ST_PLAY   = 3'd6,
    ST_DELAY  = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic             stop;
    logic             voiced;
    logic             silence;
    logic [LEN_W-1:0] len_init;
    logic [RPT_W-1:0] rpt;
  } ctrl_rec_t;
endpackage

// File: rtl/spk_seq_next.sv
module spk_seq_next
  import spk_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic       start,
  input  logic       len_carry,
  input  logic       stop,
  output seq_state_e nxt
);
  always_comb begin
    nxt = state;
    if (start) begin
      nxt = ST_WAIT;
    end else begin
      unique case (state)
        ST_IDLE:   nxt = ST_IDLE;
        ST_WAIT:   nxt = ST_PTR_HI;
        ST_PTR_HI: nxt = ST_PTR_LO;
        ST_PTR_LO: nxt = ST_BASE;
        ST_BASE:   nxt = ST_CTRL;
        ST_CTRL:   nxt = ST_PLAY;
        ST_PLAY:   nxt = len_carry ? (stop ? ST_DELAY : ST_BASE) : ST_PLAY;
        ST_DELAY:  nxt = ST_IDLE;
        default:   nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spk_seq_ptr.sv
module spk_seq_ptr
  import spk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [WORD_W-1:0] word_num,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] ptr_asm,
  output logic [WORD_W-1:0] word_q
);
  // low nibble of the pointer comes from the upper nibble of the second byte
  assign ptr_asm = ptr_q | ADDR_W'(rom_data[DATA_W-1 -: NIB_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      word_q <= '0;
    end else begin
      unique case (state)
        ST_WAIT:         word_q <= word_num;
        ST_PTR_HI:       ptr_q  <= {rom_data, {NIB_W{1'b0}}};
        ST_PTR_LO:       ptr_q  <= ptr_asm;
        ST_BASE, ST_CTRL: ptr_q <= ptr_q + ADDR_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spk_seq_rec.sv
module spk_seq_rec
  import spk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [DATA_W-1:0] rom_data,
  output logic [BASE_W-1:0] base_q,
  output logic              base_stb,
  output ctrl_rec_t         rec_q,
  output logic              rec_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      base_stb <= 1'b0;
      rec_q    <= '0;
      rec_stb  <= 1'b0;
    end else begin
      base_stb <= (state == ST_BASE);
      rec_stb  <= (state == ST_CTRL);
      if (state == ST_BASE) base_q <= {rom_data, 1'b0};
      if (state == ST_CTRL) begin
        rec_q.stop     <= rom_data[7];
        rec_q.voiced   <= rom_data[6];
        rec_q.silence  <= rom_data[5];
        rec_q.len_init <= {rom_data[FIELD_W-1:0], {LEN_SH{1'b0}}};
        rec_q.rpt      <= rom_data[RPT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spk_word_seq.sv
module spk_word_seq
  import spk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_num,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [ADDR_W-1:0] play_addr,
  input  logic              len_carry,
  input  logic [SAMP_W-1:0] dec_sample,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              busy,
  output logic              play_en,
  output logic [SAMP_W-1:0] audio_out,
  output logic              dbase_load,
  output logic [BASE_W-1:0] data_base,
  output logic              ctrl_load,
  output logic              stop_flag,
  output logic              voiced_flag,
  output logic              silence_flag,
  output logic [LEN_W-1:0]  len_init,
  output logic [RPT_W-1:0]  rpt_reload
);
  seq_state_e        state, nxt;
  logic [ADDR_W-1:0] ptr_q, ptr_asm, addr_d;
  logic [WORD_W-1:0] word_q;
  ctrl_rec_t         rec_q;

  spk_seq_next u_next (
    .state(state), .start(start), .len_carry(len_carry),
    .stop(rec_q.stop), .nxt(nxt)
  );

  spk_seq_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .state(state), .word_num(word_num),
    .rom_data(rom_data), .ptr_q(ptr_q), .ptr_asm(ptr_asm), .word_q(word_q)
  );

  spk_seq_rec u_rec (
    .clk(clk), .rst_n(rst_n), .state(state), .rom_data(rom_data),
    .base_q(data_base), .base_stb(dbase_load), .rec_q(rec_q), .rec_stb(ctrl_load)
  );

  always_comb begin
    addr_d = rom_addr;
    unique case (state)
      ST_WAIT:   addr_d = ADDR_W'({word_num, 1'b0});
      ST_PTR_HI: addr_d = ADDR_W'({word_q, 1'b1});
      ST_PTR_LO: addr_d = ptr_asm;
      ST_BASE:   addr_d = ptr_q + ADDR_W'(1);
      ST_CTRL:   addr_d = {data_base, {SUB_W{1'b0}}};
      ST_PLAY:   addr_d = (len_carry && !rec_q.stop) ? ptr_q : play_addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rom_addr <= '0;
      busy     <= 1'b0;
    end else begin
      state    <= nxt;
      rom_addr <= addr_d;
      if (nxt == ST_WAIT)       busy <= 1'b1;
      else if (state == ST_IDLE) busy <= 1'b0;
    end
  end

  assign play_en      = (state == ST_PLAY);
  assign audio_out    = play_en ? dec_sample : REST_LEVEL;
  assign stop_flag    = rec_q.stop;
  assign voiced_flag  = rec_q.voiced;
  assign silence_flag = rec_q.silence;
  assign len_init     = rec_q.len_init;
  assign rpt_reload   = rec_q.rpt;
endmodule

// File: rtl/spk_word_seq_chk.sv
module spk_word_seq_chk
  import spk_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              play_en,
  input logic [ADDR_W-1:0] play_addr,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              len_carry,
  input logic [SAMP_W-1:0] audio_out,
  input logic              dbase_load,
  input logic              ctrl_load
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !play_en));

  p_base_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbase_load |=> !dbase_load);

  p_play_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_en) |-> ctrl_load);

  p_play_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && !start && !len_carry) |=> (play_en && rom_addr == $past(play_addr)));

  p_record_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbase_load && !start) |=> ctrl_load);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!play_en && audio_out == REST_LEVEL));
endmodule

bind spk_word_seq spk_word_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .play_en(play_en),
  .play_addr(play_addr), .rom_addr(rom_addr), .len_carry(len_carry),
  .audio_out(audio_out), .dbase_load(dbase_load), .ctrl_load(ctrl_load)
);

// File: tb/spk_word_seq_tb.sv
module spk_word_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  word_num = '0;
  logic [7:0]  rom_data;
  logic [11:0] play_addr = '0;
  logic        len_carry = 1'b0;
  logic [3:0]  dec_sample = '0;
  logic [11:0] rom_addr;
  logic        busy, play_en, dbase_load, ctrl_load;
  logic        stop_flag, voiced_flag, silence_flag;
  logic [3:0]  audio_out;
  logic [8:0]  data_base;
  logic [6:0]  len_init;
  logic [1:0]  rpt_reload;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    case (a)
      12'h00A: rom_fn = 8'h12;
      12'h00B: rom_fn = 8'h30;
      12'h123: rom_fn = 8'hA4;
      12'h124: rom_fn = 8'h47;
      12'h125: rom_fn = 8'h10;
      12'h126: rom_fn = 8'hB9;
      12'h004: rom_fn = 8'h05;
      12'h005: rom_fn = 8'h70;
      12'h057: rom_fn = 8'h02;
      12'h058: rom_fn = 8'hE0;
      default: rom_fn = 8'hFF;
    endcase
  endfunction
  assign rom_data = rom_fn(rom_addr);

  spk_word_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_num(word_num),
    .rom_data(rom_data), .play_addr(play_addr), .len_carry(len_carry),
    .dec_sample(dec_sample), .rom_addr(rom_addr), .busy(busy),
    .play_en(play_en), .audio_out(audio_out), .dbase_load(dbase_load),
    .data_base(data_base), .ctrl_load(ctrl_load), .stop_flag(stop_flag),
    .voiced_flag(voiced_flag), .silence_flag(silence_flag),
    .len_init(len_init), .rpt_reload(rpt_reload)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "busy", busy, 0);
    chk("R1", "rom_addr", rom_addr, 0);
    chk("R1", "audio", audio_out, 7);
    chk("R1", "play_en", play_en, 0);
    chk("R1", "strobes", {dbase_load, ctrl_load}, 0);
    rst_n = 1'b1;
    step();
    chk("R10", "idle audio", audio_out, 7);
  endtask

  task automatic t_two_records();
    start = 1'b1; word_num = 6'd5;
    step();
    chk("R2", "busy on start", busy, 1);
    step();
    chk("R2", "hold in wait", play_en, 0);
    start = 1'b0;
    step();
    chk("R3", "table addr even", rom_addr, 12'h00A);
    step();
    chk("R3", "table addr odd", rom_addr, 12'h00B);
    chk("R10", "fetch audio", audio_out, 7);
    step();
    chk("R4", "pointer", rom_addr, 12'h123);
    step();
    chk("R5", "base strobe", dbase_load, 1);
    chk("R5", "base value", data_base, 9'h148);
    chk("R5", "ctrl addr", rom_addr, 12'h124);
    play_addr = 12'h555; dec_sample = 4'd3;
    step();
    chk("R5", "base strobe single", dbase_load, 0);
    chk("R6", "ctrl strobe", ctrl_load, 1);
    chk("R6", "play_en", play_en, 1);
    chk("R6", "flags s/v/q", {stop_flag, voiced_flag, silence_flag}, 3'b010);
    chk("R6", "len_init", len_init, 7'h1C);
    chk("R6", "rpt", rpt_reload, 2'd3);
    chk("R6", "data addr", rom_addr, 12'hA40);
    step();
    chk("R7", "play addr", rom_addr, 12'h555);
    chk("R7", "audio follows", audio_out, 3);
    dec_sample = 4'd12;
    #1 chk("R7", "audio follows 2", audio_out, 12);
    len_carry = 1'b1;
    step();
    len_carry = 1'b0;
    chk("R8", "next record addr", rom_addr, 12'h125);
    chk("R8", "left play", play_en, 0);
    chk("R10", "audio after play", audio_out, 7);
    step();
    chk("R8", "second base", data_base, 9'h020);
    chk("R8", "second ctrl addr", rom_addr, 12'h126);
    step();
    chk("R6", "flags rec2", {stop_flag, voiced_flag, silence_flag}, 3'b101);
    chk("R6", "len rec2", len_init, 7'h64);
    chk("R6", "rpt rec2", rpt_reload, 2'd1);
    chk("R6", "data addr rec2", rom_addr, 12'h100);
    len_carry = 1'b1;
    step();
    len_carry = 1'b0;
    chk("R9", "delay not play", play_en, 0);
    chk("R9", "busy in delay", busy, 1);
    step();
    chk("R9", "busy first idle", busy, 1);
    step();
    chk("R9", "busy dropped", busy, 0);
    chk("R10", "idle audio end", audio_out, 7);
  endtask

  task automatic t_abort();
    start = 1'b1; word_num = 6'd2;
    step();
    start = 1'b0; len_carry = 1'b1;
    step();
    chk("R11", "addr with carry", rom_addr, 12'h004);
    step();
    chk("R11", "addr odd with carry", rom_addr, 12'h005);
    step();
    chk("R11", "pointer with carry", rom_addr, 12'h057);
    step();
    chk("R11", "base with carry", data_base, 9'h004);
    step();
    len_carry = 1'b0;
    chk("R11", "play reached", play_en, 1);
    chk("R6", "all flags", {stop_flag, voiced_flag, silence_flag}, 3'b111);
    start = 1'b1;
    step();
    chk("R2", "abort leaves play", play_en, 0);
    chk("R2", "abort busy", busy, 1);
    chk("R10", "abort audio", audio_out, 7);
    word_num = 6'd5;
    step();
    chk("R2", "still waiting", play_en, 0);
    start = 1'b0;
    step();
    chk("R3", "restart addr", rom_addr, 12'h00A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_two_records();
    t_abort();
    finish_run();
  end
endmodule